// File: doc/BRIEF.md
# Per-Pin Input Qualification Filter

This block conditions a bank of raw input pins before they reach the general-purpose data path or a peripheral. Each pin has its own two-bit mode. The mode selects one of four treatments: a plain two-flop synchronizer, a debounce filter that needs three agreeing samples, a debounce filter that needs six agreeing samples, or a direct asynchronous path. The asynchronous path is allowed only on pins that are assigned to a peripheral. A pin in general-purpose use that requests the asynchronous mode is given the synchronizer path instead.

The filters take their samples from the synchronized signal, at the rate of a shared sample strobe. A divider value N sets that strobe to one pulse every 2×N clocks, and N = 0 gives one sample every clock. A longer spacing stretches the window, so a wider noise pulse is rejected. All pin signals are levels with no transfer semantics. The block therefore has no valid/ready handshake and applies no back-pressure: an output is a level that is true from the clock in which it changes until its next change.

Top module: `pin_qual_filter`

## Requirements
- R1: Each pin has its own mode, read from bits [2i+1:2i] of `qual_mode`: 0 = synchronize only, 1 = three-sample filter, 2 = six-sample filter, 3 = asynchronous. Pins in different modes can operate at the same time without affecting each other.
- R2: In mode 0, `pin_qual[i]` equals `pin_raw[i]` delayed by exactly two rising clock edges.
- R3: In mode 1 with N = 0, a level change on the pin reaches the output on the fifth rising edge after the change. The output changes only when three consecutive samples agree on the new level.
- R4: In mode 2 with N = 0, a level change reaches the output on the eighth rising edge after the change.
- R5: A pulse whose samples do not agree for the full window is ignored and the output holds its value. With N = 0, a 2-clock pulse is rejected in mode 1 and a 5-clock pulse is rejected in mode 2. A 3-clock pulse in mode 1 is passed.
- R6: The sample strobe fires every clock when `samp_div` = 0 and every 2×N clocks otherwise. With N = 2 in mode 1, a level change does not appear before edge 11 and is present by edge 14. A 3-clock pulse is rejected.
- R7: In mode 3 on a pin whose `periph_sel` bit is 1, `pin_qual[i]` follows `pin_raw[i]` combinationally, with no clock of delay.
- R8: In mode 3 on a pin whose `periph_sel` bit is 0, the pin behaves exactly as in mode 0.
- R9: During reset and directly after it, every pin not on the asynchronous path reads 0. The filtered outputs stay at 0 until their first full window of agreeing samples after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | NPINS | Raw pin levels, asynchronous to clk |
| qual_mode | input | 2*NPINS | Per-pin mode fields, two bits per pin |
| samp_div | input | DIVW | Sampling period divider N, strobe every 2×N clocks |
| periph_sel | input | NPINS | 1 = pin feeds a peripheral, so async mode is permitted |
| pin_qual | output | NPINS | Conditioned pin levels |

## Verification
A fault in the synchronizer shows up as a change in the edge at which a mode-0 output moves. The bench catches it within two clocks of a pin change. A wrong sample history or window comparison either lets a short pulse reach the output or moves the qualifying edge away from edge 5 or edge 8. That difference shows up within eight clocks, and the bench checks the output at every edge in between. A wrong strobe counter shifts the qualifying edge outside the 11 to 14 band, or lets a 3-clock pulse through when N = 2. The bench therefore reads the divided case over a window of about twenty clocks.

// File: rtl/pqf_pkg.sv
package pqf_pkg;
  typedef enum logic [1:0] {
    QM_SYNC  = 2'd0,
    QM_WIN3  = 2'd1,
    QM_WIN6  = 2'd2,
    QM_ASYNC = 2'd3
  } qmode_e;

  localparam int WIN_SHORT = 3;
  localparam int WIN_LONG  = 6;
  localparam int FILL_W    = $clog2(WIN_LONG + 1);
endpackage

// File: rtl/pqf_sample_tick.sv
module pqf_sample_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] samp_div,
  output logic            tick
);
  localparam int CW = DIVW + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  // period is 2*N clocks: count 0 .. 2N-1
  assign lim  = {samp_div, 1'b0} - CW'(1);
  assign tick = (samp_div == '0) || (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  // R6: with a nonzero divider held steady, two strobes never fall on adjacent clocks
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && samp_div != '0) |=> (!tick || !$stable(samp_div)));
endmodule

// File: rtl/pqf_sync2.sv
module pqf_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/pqf_pin_lane.sv
module pqf_pin_lane
  import pqf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   sync_in,
  input  qmode_e mode,
  output logic   q_filt
);
  localparam logic [FILL_W-1:0] FILL_MAX   = FILL_W'(WIN_LONG);
  localparam logic [FILL_W-1:0] NEED_SHORT = FILL_W'(WIN_SHORT);

  logic [WIN_LONG-1:0] hist;
  logic [WIN_LONG-1:0] win_next;
  logic [FILL_W-1:0]   fill, fill_next;
  logic                agree3, agree6, take;

  always_comb begin
    win_next  = {hist[WIN_LONG-2:0], sync_in};
    fill_next = (fill == FILL_MAX) ? fill : fill + FILL_W'(1);
    agree3 = (fill_next >= NEED_SHORT) &&
             ((win_next[WIN_SHORT-1:0] == '0) || (win_next[WIN_SHORT-1:0] == '1));
    agree6 = (fill_next == FILL_MAX) &&
             ((win_next == '0) || (win_next == '1));
    take   = ((mode == QM_WIN3) && agree3) || ((mode == QM_WIN6) && agree6);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      fill   <= '0;
      q_filt <= 1'b0;
    end else if (tick) begin
      hist <= win_next;
      fill <= fill_next;
      if (take) q_filt <= sync_in;
    end
  end

  // R3: the filtered level moves only on a sample strobe
  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(q_filt));
  // R5: a new filtered level is always the level that was just sampled
  assert_new_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_filt) |-> (q_filt == $past(sync_in)));
  // R9: before a short window has been collected the output keeps its reset level
  assert_reset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill < NEED_SHORT) |-> (q_filt == 1'b0));
endmodule

// File: rtl/pin_qual_filter.sv
module pin_qual_filter
  import pqf_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int DIVW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_raw,
  input  logic [2*NPINS-1:0] qual_mode,
  input  logic [DIVW-1:0]    samp_div,
  input  logic [NPINS-1:0]   periph_sel,
  output logic [NPINS-1:0]   pin_qual
);
  logic             tick;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pin_filt;
  logic [1:0]       age;

  pqf_sample_tick #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst_n(rst_n), .samp_div(samp_div), .tick(tick)
  );

  pqf_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_raw), .q_sync(pin_sync)
  );

  // cycles since reset, for the delay checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    qmode_e md;
    logic   via_sync;
    assign md = qmode_e'(qual_mode[2*i +: 2]);
    // async is honoured only for peripheral pins (R7/R8)
    assign via_sync = (md == QM_SYNC) || ((md == QM_ASYNC) && !periph_sel[i]);

    pqf_pin_lane u_lane (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .sync_in(pin_sync[i]), .mode(md), .q_filt(pin_filt[i])
    );

    always_comb begin
      unique case (md)
        QM_WIN3, QM_WIN6: pin_qual[i] = pin_filt[i];
        QM_ASYNC:         pin_qual[i] = periph_sel[i] ? pin_raw[i] : pin_sync[i];
        default:          pin_qual[i] = pin_sync[i];
      endcase
    end

    // R2 and R8: a synchronized pin reproduces its raw level two edges later
    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && via_sync && $past(via_sync) && $past(via_sync, 2))
      |-> (pin_qual[i] == $past(pin_raw[i], 2)));
  end
endmodule

// File: tb/sim_pin_qual_filter.sv
module sim_pin_qual_filter;
  localparam int NPINS = 8;
  localparam int DIVW  = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NPINS-1:0]   pin_raw = '0;
  logic [2*NPINS-1:0] qual_mode = '0;
  logic [DIVW-1:0]    samp_div = '0;
  logic [NPINS-1:0]   periph_sel = '0;
  logic [NPINS-1:0]   pin_qual;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pin_qual_filter #(.NPINS(NPINS), .DIVW(DIVW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .qual_mode(qual_mode),
    .samp_div(samp_div), .periph_sel(periph_sel), .pin_qual(pin_qual)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_pin(input int p, input logic exp, input string tag);
    chk(pin_qual[p] === exp, tag, int'(pin_qual[p]), int'(exp));
  endtask

  task automatic set_mode(input int p, input logic [1:0] m);
    qual_mode[2*p +: 2] = m;
  endtask

  task automatic edge_then_sample();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // R9: reset state and hold until a full window after reset
  task automatic t_reset_hold();
    rst_n = 1'b0;
    periph_sel = '0;
    qual_mode = '0;
    set_mode(1, 2'd1);
    set_mode(2, 2'd2);
    pin_raw = '1;
    idle(3);
    chk(pin_qual === '0, "R9 outputs in reset", int'(pin_qual), 0);
    rst_n = 1'b1;
    #1;
    chk(pin_qual === '0, "R9 outputs at release", int'(pin_qual), 0);
    for (int e = 1; e <= 8; e++) begin
      edge_then_sample();
      chk_pin(0, e >= 2, "R9 sync pin after reset");
      chk_pin(1, e >= 5, "R9 three-sample pin after reset");
      chk_pin(2, e >= 8, "R9 six-sample pin after reset");
    end
    pin_raw = '0;
    idle(12);
  endtask

  // R1 R2 R3 R4 R7 R8 and R6 (N=0): all modes side by side
  task automatic t_modes();
    samp_div = '0;
    qual_mode = '0;
    set_mode(0, 2'd0);
    set_mode(1, 2'd1);
    set_mode(2, 2'd2);
    set_mode(3, 2'd3);
    set_mode(4, 2'd3);
    periph_sel = 8'b0000_1000;
    pin_raw = '0;
    idle(12);
    for (int lvl = 1; lvl >= 0; lvl--) begin
      pin_raw[4:0] = lvl[0] ? 5'h1F : 5'h00;
      #1;
      chk_pin(3, lvl[0], "R7 async peripheral pin same cycle");
      chk_pin(0, !lvl[0], "R2 sync pin before edges");
      for (int e = 1; e <= 8; e++) begin
        edge_then_sample();
        chk_pin(0, (e >= 2) ? lvl[0] : !lvl[0], "R2 sync pin delay");
        chk_pin(4, (e >= 2) ? lvl[0] : !lvl[0], "R8 async mode on gpio pin");
        chk_pin(1, (e >= 5) ? lvl[0] : !lvl[0], "R3 three-sample latency");
        chk_pin(2, (e >= 8) ? lvl[0] : !lvl[0], "R4 six-sample latency");
        chk_pin(3, lvl[0], "R7 async pin steady");
        chk_pin(5, 1'b0, "R1 untouched pin");
      end
      @(negedge clk);
      idle(4);
    end
  endtask

  // R5: short pulses rejected, pulse equal to the window passed
  task automatic t_glitch();
    samp_div = '0;
    periph_sel = '0;
    qual_mode = '0;
    set_mode(1, 2'd1);
    set_mode(2, 2'd2);
    pin_raw = '0;
    idle(10);
    pin_raw[1] = 1'b1;
    idle(1);
    @(posedge clk); @(negedge clk);
    pin_raw[1] = 1'b0;
    pin_raw[2] = 1'b1;
    for (int k = 0; k < 5; k++) @(negedge clk);
    pin_raw[2] = 1'b0;
    for (int k = 0; k < 12; k++) begin
      edge_then_sample();
      chk_pin(1, 1'b0, "R5 2-clock pulse ignored in mode 1");
      chk_pin(2, 1'b0, "R5 5-clock pulse ignored in mode 2");
    end
    @(negedge clk);
    pin_raw[1] = 1'b1;
    for (int e = 1; e <= 8; e++) begin
      if (e == 4) pin_raw[1] = 1'b0;
      edge_then_sample();
      chk_pin(1, (e >= 5 && e <= 7), "R5 3-clock pulse passed in mode 1");
      @(negedge clk);
      if (e == 3) pin_raw[1] = 1'b0;
    end
    idle(6);
  endtask

  // R6: divided strobe, N=2 gives a sample every 4 clocks
  task automatic t_divider();
    periph_sel = '0;
    qual_mode = '0;
    set_mode(1, 2'd1);
    samp_div = 8'd2;
    pin_raw = '0;
    idle(20);
    pin_raw[1] = 1'b1;
    for (int e = 1; e <= 14; e++) begin
      edge_then_sample();
      if (e <= 10) chk_pin(1, 1'b0, "R6 no early take with N=2");
      if (e == 14) chk_pin(1, 1'b1, "R6 level taken by edge 14 with N=2");
    end
    @(negedge clk);
    idle(4);
    pin_raw[1] = 1'b0;
    for (int k = 0; k < 3; k++) @(negedge clk);
    pin_raw[1] = 1'b1;
    for (int k = 0; k < 20; k++) begin
      edge_then_sample();
      chk_pin(1, 1'b1, "R6 3-clock dip ignored with N=2");
    end
    @(negedge clk);
    samp_div = '0;
    pin_raw = '0;
    idle(20);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_hold();
    t_modes();
    t_glitch();
    t_divider();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule